// File: doc/BRIEF.md
# Interleaved I/Q De-interleaver

This block sits in front of a pair of transmit interpolation filters and splits one shared data bus that carries I and Q samples in turns. Each bus word is written into the I side or the Q side according to a channel-select input sampled together with a write enable. The write enable is a synchronous qualifier in the sample clock domain. A small pairing state machine holds a pending I word until its Q partner arrives. It then hands both words to the output registers on the same sample-clock edge, so the two filters always see a matched pair.

A single active-high power-control input is decoded by how long it stays high. If it stays high for at least `SLEEP_CYCLES` consecutive clocks, the block goes to sleep: the output words read as zero and pairing is frozen until the input drops. A shorter pulse acts as a functional clear of all captured data and pairing state. It takes effect on the edge where the input is first seen low again. The usual synchronous active-low reset of the chip is also provided.

Top module: `iq_deinterleaver`

## Requirements
- R1: The data bus is `DATA_W` bits wide, bit `DATA_W-1` being the MSB. A captured word reaches `i_word` or `q_word` with every bit in its original position.
- R2: A write with `sel_i` = 1 stores the bus word as the pending I word. A write with `sel_i` = 0 supplies the Q word of a pair.
- R3: A pair is released only by a Q write that follows an I write. A Q write with no pending I word is discarded: `pair_valid` stays low and the outputs keep their values.
- R4: A second I write before the Q write replaces the pending I word. The later word is the one that is paired.
- R5: On the clock edge that samples the completing Q write, `i_word` and `q_word` both load the new pair and `pair_valid` goes high for exactly one cycle. Between pairs, both outputs hold their values.
- R6: If `pwr_ctl` is sampled high on `SLEEP_CYCLES` (default 4) consecutive edges, `sleep_active` rises after the last of them and not before. It falls after the first edge that samples `pwr_ctl` low.
- R7: If `pwr_ctl` is high on 1 to `SLEEP_CYCLES-1` consecutive edges and then low, the edge that samples it low clears the pending I word, the pairing state and both output words, and gives no `pair_valid`.
- R8: While `pwr_ctl` is high, writes are ignored. While `sleep_active` is high, `i_word` and `q_word` read zero and `pair_valid` stays low. Leaving sleep clears nothing: the held pair reappears and a pending I word is still paired with the next Q write.
- R9: `rst_n` low on a clock edge clears the outputs, the pending I word, the pairing state, `pair_valid` and `sleep_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | DATA_W | Shared interleaved I/Q data bus |
| wr_en | input | 1 | Write qualifier, sampled on the clock |
| sel_i | input | 1 | Channel select: 1 = I, 0 = Q |
| pwr_ctl | input | 1 | Active-high clear/sleep control, decoded by pulse length |
| i_word | output | DATA_W | Paired I word to the I filter |
| q_word | output | DATA_W | Paired Q word to the Q filter |
| pair_valid | output | 1 | One-cycle pulse when a new pair is loaded |
| sleep_active | output | 1 | High while in sleep mode |

## Verification
The bench builds the block with `DATA_W` = 4 and `SLEEP_CYCLES` = 4. At that width every one of the 256 I/Q value combinations is pushed through a complete write pair, and each is checked for correct pairing, bit positions and output hold. Every control pulse length from one clock up to two clocks beyond the sleep threshold is applied. This covers the exact boundary between clear and sleep, writes attempted while the control input is high, and a pending I word surviving sleep.

// File: rtl/iqd_pkg.sv
// Package: shared types for the I/Q de-interleaver.
// Assumes: nothing beyond IEEE 1800-2017.
package iqd_pkg;

    // Pairing state: either no I word is waiting, or one I word waits for its Q partner.
    typedef enum logic {
        PAIR_EMPTY  = 1'b0,
        PAIR_HAVE_I = 1'b1
    } pair_state_t;

endpackage

// File: rtl/iqd_pin_decode.sv
// Module: iqd_pin_decode
// Decodes the single power-control input by how long it stays high.
// A run of SLEEP_CYCLES or more sampled-high edges raises sleep.
// A shorter run produces a one-cycle clear on the edge that samples the input low.
// Assumes: pwr_ctl is already synchronous to clk.
module iqd_pin_decode #(
    parameter int SLEEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ctl,
    output logic hold_o,
    output logic clear_o,
    output logic sleep_o
);

    localparam int CNT_W = $clog2(SLEEP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(SLEEP_CYCLES);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(SLEEP_CYCLES - 1);

    logic [CNT_W-1:0] high_cnt;
    logic             sleep_q;

    // Count consecutive high samples (saturating) and set sleep once the threshold is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
            sleep_q  <= 1'b0;
        end else if (pwr_ctl) begin
            if (high_cnt < LIMIT) begin
                high_cnt <= high_cnt + CNT_W'(1);
            end
            sleep_q <= (high_cnt >= LIMIT_M1);
        end else begin
            high_cnt <= '0;
            sleep_q  <= 1'b0;
        end
    end

    // A short run that has just ended acts as a clear.
    always_comb begin
        clear_o = !pwr_ctl && (high_cnt != '0) && (high_cnt < LIMIT);
    end

    // Any high sample blocks writes, since the pulse may still turn into a clear or sleep.
    always_comb begin
        hold_o  = pwr_ctl;
        sleep_o = sleep_q;
    end

    // R6: sleep is left on the edge after the input is seen low.
    a_r6_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ctl |=> !sleep_q);

    // R6: sleep can only start while the input is held high.
    a_r6_sleep_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> $past(pwr_ctl));

    // R7: ending a sleep-length pulse never produces a clear.
    a_r7_no_clear_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |-> !clear_o);

endmodule

// File: rtl/iqd_pair_fsm.sv
// Module: iqd_pair_fsm
// Steers bus writes into a pending I register and, on a Q write that follows an I write,
// loads the matched pair into the output registers with a one-cycle strobe.
// Assumes: wr_en is a synchronous qualifier. Clear has priority over hold, and hold over writes.
module iqd_pair_fsm
    import iqd_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              hold,
    input  logic              wr_en,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] pair_i,
    output logic [DATA_W-1:0] pair_q,
    output logic              pair_stb
);

    pair_state_t       st_q;
    logic [DATA_W-1:0] pend_i;

    // Capture writes, advance the pairing state and release the completed pairs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st_q     <= PAIR_EMPTY;
            pend_i   <= '0;
            pair_i   <= '0;
            pair_q   <= '0;
            pair_stb <= 1'b0;
        end else begin
            pair_stb <= 1'b0;
            if (wr_en && !hold) begin
                if (sel_i) begin
                    pend_i <= data;
                    st_q   <= PAIR_HAVE_I;
                end else if (st_q == PAIR_HAVE_I) begin
                    pair_i   <= pend_i;
                    pair_q   <= data;
                    pair_stb <= 1'b1;
                    st_q     <= PAIR_EMPTY;
                end
            end
        end
    end

    // R5: the strobe is a single-cycle pulse.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_stb |=> !pair_stb);

    // R3: a pair is released only when an I word was waiting.
    a_r3_needs_pending_i: assert property (@(posedge clk) disable iff (!rst_n)
        pair_stb |-> $past(st_q) == PAIR_HAVE_I);

    // R7: a clear empties the pairing state and the outputs.
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q == PAIR_EMPTY) && (pair_i == '0) && (pair_q == '0) && !pair_stb);

    // R8: while held, the pending word and the state do not move and no pair is released.
    a_r8_frozen_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(pend_i) && $stable(st_q) && !pair_stb);

    // R5: outputs keep their values when no pair is released.
    a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(wr_en && !hold && !sel_i)) |=> $stable(pair_i) && $stable(pair_q));

endmodule

// File: rtl/iqd_out_mask.sv
// Module: iqd_out_mask
// Forces both output words to zero while the block sleeps. The two channels share one template.
// Assumes: the sleep flag is registered, so the mask adds no extra register stage.
module iqd_out_mask #(
    parameter int DATA_W = 10,
    parameter int N_CH   = 2
) (
    input  logic [N_CH-1:0][DATA_W-1:0] words_in,
    input  logic                        sleep,
    output logic [N_CH-1:0][DATA_W-1:0] words_out
);

    // One zero-forcing gate per channel.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        always_comb begin
            words_out[ch] = sleep ? '0 : words_in[ch];
        end
    end

endmodule

// File: rtl/iq_deinterleaver.sv
// Module: iq_deinterleaver (top)
// Splits an interleaved I/Q bus into paired I and Q words and decodes the power-control input.
// Assumes: all inputs are synchronous to clk. rst_n is synchronous and active low.
module iq_deinterleaver #(
    parameter int DATA_W       = 10,
    parameter int SLEEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              wr_en,
    input  logic              sel_i,
    input  logic              pwr_ctl,
    output logic [DATA_W-1:0] i_word,
    output logic [DATA_W-1:0] q_word,
    output logic              pair_valid,
    output logic              sleep_active
);

    localparam int N_CH = 2;

    logic                        hold;
    logic                        clear;
    logic                        sleep;
    logic [DATA_W-1:0]           pair_i;
    logic [DATA_W-1:0]           pair_q;
    logic                        pair_stb;
    logic [N_CH-1:0][DATA_W-1:0] raw_words;
    logic [N_CH-1:0][DATA_W-1:0] out_words;

    iqd_pin_decode #(
        .SLEEP_CYCLES(SLEEP_CYCLES)
    ) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_ctl (pwr_ctl),
        .hold_o  (hold),
        .clear_o (clear),
        .sleep_o (sleep)
    );

    iqd_pair_fsm #(
        .DATA_W(DATA_W)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .hold     (hold),
        .wr_en    (wr_en),
        .sel_i    (sel_i),
        .data     (bus_data),
        .pair_i   (pair_i),
        .pair_q   (pair_q),
        .pair_stb (pair_stb)
    );

    // Pack both channels for the shared mask template.
    always_comb begin
        raw_words[0] = pair_i;
        raw_words[1] = pair_q;
    end

    iqd_out_mask #(
        .DATA_W(DATA_W),
        .N_CH  (N_CH)
    ) u_mask (
        .words_in  (raw_words),
        .sleep     (sleep),
        .words_out (out_words)
    );

    // Drive the ports from the masked words and the control flags.
    always_comb begin
        i_word       = out_words[0];
        q_word       = out_words[1];
        pair_valid   = pair_stb;
        sleep_active = sleep;
    end

    // R8: no pair is released while asleep.
    a_r8_no_pair_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> !pair_valid);

    // R9: reset leaves the outputs cleared and idle.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (i_word == '0) && (q_word == '0) && !pair_valid && !sleep_active);

endmodule

// File: tb/iq_deinterleaver_tb_top.sv
module iq_deinterleaver_tb_top;

    localparam int W  = 4;
    localparam int SC = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] bus_data;
    logic         wr_en;
    logic         sel_i;
    logic         pwr_ctl;
    logic [W-1:0] i_word;
    logic [W-1:0] q_word;
    logic         pair_valid;
    logic         sleep_active;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    iq_deinterleaver #(
        .DATA_W      (W),
        .SLEEP_CYCLES(SC)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_data    (bus_data),
        .wr_en       (wr_en),
        .sel_i       (sel_i),
        .pwr_ctl     (pwr_ctl),
        .i_word      (i_word),
        .q_word      (q_word),
        .pair_valid  (pair_valid),
        .sleep_active(sleep_active)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write cycle. Returns at the negedge after the sampling edge.
    task automatic wr(input bit s, input int d);
        @(negedge clk);
        wr_en    = 1'b1;
        sel_i    = s;
        bus_data = W'(d);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_data = '0; wr_en = 1'b0; sel_i = 1'b0; pwr_ctl = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset i_word", int'(i_word), 0);
        check("R9 reset q_word", int'(q_word), 0);
        check("R9 reset pair_valid", int'(pair_valid), 0);
        check("R9 reset sleep_active", int'(sleep_active), 0);
        rst_n = 1'b1;

        // R1 R2 R5: every I/Q value combination through a full pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                wr(1'b1, a);
                check("R3 I alone gives no pair", int'(pair_valid), 0);
                wr(1'b0, b);
                check("R5 pair_valid on Q write", int'(pair_valid), 1);
                check("R1 R2 i_word", int'(i_word), a);
                check("R1 R2 q_word", int'(q_word), b);
                @(negedge clk);
                check("R5 pair_valid one cycle", int'(pair_valid), 0);
                check("R5 i_word held", int'(i_word), a);
                check("R5 q_word held", int'(q_word), b);
            end
        end

        // R1: MSB alone lands in the MSB position
        wr(1'b1, 1 << (W - 1));
        wr(1'b0, 1);
        check("R1 MSB position i_word", int'(i_word), 1 << (W - 1));
        check("R1 LSB position q_word", int'(q_word), 1);

        // R3: Q write without a pending I word is discarded
        wr(1'b0, 5);
        check("R3 orphan Q no pair", int'(pair_valid), 0);
        check("R3 orphan Q i held", int'(i_word), 1 << (W - 1));
        check("R3 orphan Q q held", int'(q_word), 1);

        // R4: second I write replaces the pending word
        wr(1'b1, 3);
        wr(1'b1, 9);
        wr(1'b0, 7);
        check("R4 replaced I pairs", int'(i_word), 9);
        check("R4 q_word", int'(q_word), 7);

        // R7: short pulses of 1..SC-1 clocks clear everything
        for (int len = 1; len < SC; len++) begin
            wr(1'b1, 2);
            wr(1'b0, 6);
            wr(1'b1, 11);
            @(negedge clk);
            pwr_ctl = 1'b1;
            repeat (len) @(negedge clk);
            check("R6 no sleep before threshold", int'(sleep_active), 0);
            pwr_ctl = 1'b0;
            @(negedge clk);
            check("R7 clear i_word", int'(i_word), 0);
            check("R7 clear q_word", int'(q_word), 0);
            check("R7 clear no pair", int'(pair_valid), 0);
            check("R7 clear no sleep", int'(sleep_active), 0);
            wr(1'b0, 4);
            check("R7 pending I cleared", int'(pair_valid), 0);
        end

        // R6 R8: pulses of SC..SC+2 clocks enter sleep
        for (int len = SC; len < SC + 3; len++) begin
            wr(1'b1, 5);
            wr(1'b0, 12);
            wr(1'b1, len + 7);
            @(negedge clk);
            pwr_ctl = 1'b1;
            repeat (SC - 1) @(negedge clk);
            check("R6 sleep not yet", int'(sleep_active), 0);
            check("R6 outputs live before sleep", int'(i_word), 5);
            @(negedge clk);
            check("R6 sleep entered", int'(sleep_active), 1);
            check("R8 i_word zero in sleep", int'(i_word), 0);
            check("R8 q_word zero in sleep", int'(q_word), 0);
            for (int k = SC; k < len; k++) @(negedge clk);
            wr(1'b1, 1);
            wr(1'b0, 2);
            check("R8 writes ignored in sleep", int'(pair_valid), 0);
            check("R8 still zero", int'(q_word), 0);
            pwr_ctl = 1'b0;
            @(negedge clk);
            check("R6 sleep left", int'(sleep_active), 0);
            check("R8 held i after sleep", int'(i_word), 5);
            check("R8 held q after sleep", int'(q_word), 12);
            wr(1'b0, 3);
            check("R8 pending kept pair", int'(pair_valid), 1);
            check("R8 pending kept i", int'(i_word), len + 7);
            check("R8 pending kept q", int'(q_word), 3);
        end

        // R9: reset in mid-operation
        wr(1'b1, 7);
        wr(1'b0, 8);
        wr(1'b1, 9);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 mid reset i_word", int'(i_word), 0);
        check("R9 mid reset q_word", int'(q_word), 0);
        wr(1'b0, 1);
        check("R9 pending I gone", int'(pair_valid), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule